// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a processor's memory stage and a 32-bit data memory that is addressed by word. For each request it adds a sign-extended 16-bit offset to a base register value to form the byte address. It then drives the word address, a read or write strobe and a per-byte enable mask. Store data moves from the low end of the source register onto the byte lanes that the address selects. For loads, the returned word is shifted down and zero- or sign-extended according to the opcode. The result is registered and presented one cycle after the read data arrives. The memory is little-endian, and address bits 1:0 pick the byte lane.

Control is a two-state machine. `S_IDLE` accepts any request. An aligned load moves it to `S_WAIT` (transition *issue_load*). In `S_WAIT` the block holds off new requests until read data returns. In that same cycle it completes the load and may accept a new request. It stays in `S_WAIT` if that request is another aligned load (*chain_load*). Otherwise it returns to `S_IDLE` (*complete*). While `S_WAIT` sees no data, the transition is *hold*. Stores, misaligned accesses and non-memory opcodes leave the state unchanged (*idle_stay*).

A request that breaks the alignment rule for its size produces no memory access. The block signals it with a one-cycle error pulse.

Top module: `lsu_lane_aligner`

## Requirements
- R1: The byte address is `req_base` plus `req_offset` sign-extended from 16 bits, modulo 2^32. `mem_addr` carries bits 31:2 of that address in the cycle the request is accepted.
- R2: Opcodes 0x03–0x07 are loads and 0x08–0x0A are stores. Any other opcode starts no access: `mem_re`, `mem_we` and `mem_be` stay 0, and no error and no result follow.
- R3: During an access, `mem_be` is 4'b0001 shifted left by address bits 1:0 for a byte access, 4'b0011 shifted left by them for a half-word access, and 4'b1111 for a word access.
- R4: An aligned store asserts `mem_we`. Every enabled lane of `mem_wdata` carries the matching byte of the low byte (0x08), the low half-word (0x09) or the whole word (0x0A) of `req_wdata`.
- R5: Opcode 0x03 (byte) and 0x05 (half-word) return the addressed lanes zero-extended to 32 bits.
- R6: Opcode 0x04 (byte) and 0x06 (half-word) return the addressed lanes sign-extended from their top bit.
- R7: Opcode 0x07 returns the full read word unchanged.
- R8: Byte accesses are always aligned. Half-word accesses need address bit 0 clear, and word accesses need bits 1:0 clear. A misaligned request drives `mem_be` to 0 and asserts neither strobe. `misalign` is high for exactly the following cycle.
- R9: `ld_valid` rises in the cycle after `mem_rvalid` is seen in `S_WAIT`, lasts one cycle per load, and `ld_data` holds the result in that cycle.
- R10: After reset the block is in `S_IDLE` with `req_ready` high. In `S_WAIT`, `req_ready` follows `mem_rvalid`, so no access is issued while read data is outstanding. A request is still accepted in the cycle the data returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_op | input | 6 | Access opcode |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed address offset |
| req_wdata | input | 32 | Store source register value |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | Alignment error pulse |

## Verification
A load can complete in the same cycle that the next request is issued. The capture of the finishing load's lane, size and sign then overlaps the capture of the new request's. The bench provokes this by issuing a store, and separately a second load, in the cycle the memory returns data for the first load. It then checks that the first result carries the first load's extension and lane, and that the second access lands correctly. A stretched memory latency also shows that requests are refused while data is outstanding and accepted on the return cycle.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [5:0] {
        OP_LD_U8   = 6'h03,
        OP_LD_S8   = 6'h04,
        OP_LD_U16  = 6'h05,
        OP_LD_S16  = 6'h06,
        OP_LD_W    = 6'h07,
        OP_ST_8    = 6'h08,
        OP_ST_16   = 6'h09,
        OP_ST_W    = 6'h0A
    } mem_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic      is_load;
        logic      is_store;
        logic      sext;
        acc_size_e size;
    } acc_desc_t;

    function automatic acc_desc_t decode_op(input logic [5:0] op);
        acc_desc_t d;
        d = '{is_load: 1'b0, is_store: 1'b0, sext: 1'b0, size: SZ_BYTE};
        unique case (op)
            OP_LD_U8:  begin d.is_load = 1'b1; d.size = SZ_BYTE; end
            OP_LD_S8:  begin d.is_load = 1'b1; d.size = SZ_BYTE; d.sext = 1'b1; end
            OP_LD_U16: begin d.is_load = 1'b1; d.size = SZ_HALF; end
            OP_LD_S16: begin d.is_load = 1'b1; d.size = SZ_HALF; d.sext = 1'b1; end
            OP_LD_W:   begin d.is_load = 1'b1; d.size = SZ_WORD; end
            OP_ST_8:   begin d.is_store = 1'b1; d.size = SZ_BYTE; end
            OP_ST_16:  begin d.is_store = 1'b1; d.size = SZ_HALF; end
            OP_ST_W:   begin d.is_store = 1'b1; d.size = SZ_WORD; end
            default:   d = d;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lsu_addr_unit.sv
module lsu_addr_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int LW    = $clog2(NB)
) (
    input  logic [ADDR_W-1:0]    base,
    input  logic [OFF_W-1:0]     offset,
    input  acc_size_e            size,
    output logic [ADDR_W-LW-1:0] word_addr,
    output logic [LW-1:0]        lane,
    output logic [NB-1:0]        lane_mask,
    output logic                 aligned
);
    logic [ADDR_W-1:0] ea;

    always_comb begin
        ea        = base + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
        word_addr = ea[ADDR_W-1:LW];
        lane      = ea[LW-1:0];
        unique case (size)
            SZ_BYTE: begin
                aligned   = 1'b1;
                lane_mask = NB'(1) << lane;
            end
            SZ_HALF: begin
                aligned   = ~ea[0];
                lane_mask = NB'(3) << lane;
            end
            default: begin
                aligned   = (ea[LW-1:0] == '0);
                lane_mask = '1;
            end
        endcase
    end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8
) (
    input  logic [DATA_W-1:0] src,
    input  acc_size_e         size,
    output logic [DATA_W-1:0] lanes
);
    for (genvar i = 0; i < NB; i++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: lanes[8*i +: 8] = src[7:0];
                SZ_HALF: lanes[8*i +: 8] = src[8*(i%2) +: 8];
                default: lanes[8*i +: 8] = src[8*i +: 8];
            endcase
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int LW    = $clog2(NB)
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [LW-1:0]     lane,
    input  acc_size_e         size,
    input  logic              sext,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] shifted;

    always_comb begin
        shifted = rdata >> {lane, 3'b000};
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){sext & shifted[7]}}, shifted[7:0]};
            SZ_HALF: result = {{(DATA_W-16){sext & shifted[15]}}, shifted[15:0]};
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int LW    = $clog2(NB)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [5:0]           req_op,
    input  logic [ADDR_W-1:0]    req_base,
    input  logic [OFF_W-1:0]     req_offset,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 mem_re,
    output logic                 mem_we,
    output logic [ADDR_W-LW-1:0] mem_addr,
    output logic [NB-1:0]        mem_be,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic                 mem_rvalid,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 ld_valid,
    output logic [DATA_W-1:0]    ld_data,
    output logic                 misalign
);
    typedef enum logic {S_IDLE, S_WAIT} state_e;

    state_e            state_q, state_d;
    acc_desc_t         desc;
    logic [LW-1:0]     lane;
    logic [NB-1:0]     lane_mask;
    logic              aligned;
    logic [DATA_W-1:0] placed;
    logic [DATA_W-1:0] extracted;
    logic              in_wait;
    logic              accept, go_ld, go_st, bad;

    logic [LW-1:0]     pend_lane_q;
    acc_size_e         pend_size_q;
    logic              pend_sext_q;

    assign desc = decode_op(req_op);

    lsu_addr_unit #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_addr (
        .base      (req_base),
        .offset    (req_offset),
        .size      (desc.size),
        .word_addr (mem_addr),
        .lane      (lane),
        .lane_mask (lane_mask),
        .aligned   (aligned)
    );

    lsu_store_lanes #(.DATA_W(DATA_W)) u_st (
        .src   (req_wdata),
        .size  (desc.size),
        .lanes (placed)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
        .rdata  (mem_rdata),
        .lane   (pend_lane_q),
        .size   (pend_size_q),
        .sext   (pend_sext_q),
        .result (extracted)
    );

    // Request handshake and access strobes
    always_comb begin
        in_wait   = (state_q == S_WAIT);
        req_ready = in_wait ? mem_rvalid : 1'b1;
        accept    = req_valid & req_ready;
        go_ld     = accept & desc.is_load & aligned;
        go_st     = accept & desc.is_store & aligned;
        bad       = accept & (desc.is_load | desc.is_store) & ~aligned;
        mem_re    = go_ld;
        mem_we    = go_st;
        mem_be    = (go_ld | go_st) ? lane_mask : '0;
        mem_wdata = go_st ? placed : '0;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (go_ld) state_d = S_WAIT;             // issue_load
            S_WAIT: if (mem_rvalid) begin
                        state_d = go_ld ? S_WAIT : S_IDLE;   // chain_load / complete
                    end                                      // else hold
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs and pending-load descriptor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid    <= 1'b0;
            ld_data     <= '0;
            misalign    <= 1'b0;
            pend_lane_q <= '0;
            pend_size_q <= SZ_BYTE;
            pend_sext_q <= 1'b0;
        end else begin
            misalign <= bad;
            ld_valid <= in_wait & mem_rvalid;
            if (in_wait && mem_rvalid) ld_data <= extracted;
            if (go_ld) begin
                pend_lane_q <= lane;
                pend_size_q <= desc.size;
                pend_sext_q <= desc.sext;
            end
        end
    end
endmodule

// File: rtl/lsu_lane_aligner_chk.sv
module lsu_lane_aligner_chk #(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          mem_re,
    input logic          mem_we,
    input logic [NB-1:0] mem_be,
    input logic          mem_rvalid,
    input logic          ld_valid,
    input logic          misalign,
    input logic          wait_st
);
    a_r8_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> ($past(mem_be) == '0 && !$past(mem_we) && !$past(mem_re)));

    a_r9_result_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_rvalid && wait_st));

    a_r10_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_st && !mem_rvalid) |-> (!mem_re && !mem_we && !req_ready));

    a_r10_load_enters_wait: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> wait_st);

    a_r3_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                                || $countones(mem_be) == NB));

    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));
endmodule

bind lsu_lane_aligner lsu_lane_aligner_chk #(.NB(NB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .mem_rvalid (mem_rvalid),
    .ld_valid   (ld_valid),
    .misalign   (misalign),
    .wait_st    (in_wait)
);

// File: tb/lsu_lane_aligner_test.sv
`timescale 1ns/1ps
module lsu_lane_aligner_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_op = '0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        mem_re, mem_we;
    logic [29:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        ld_valid;
    logic [31:0] ld_data;
    logic        misalign;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lsu_lane_aligner uut (.*);

    // Memory model: 16 words, configurable extra read latency
    logic [31:0] mem [16];
    int          lat = 0;
    logic        pend = 1'b0;
    int          cnt = 0;
    logic [3:0]  pa = '0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[pa];
                pend       <= 1'b0;
            end else cnt <= cnt - 1;
        end
        if (mem_re) begin
            if (lat == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[3:0]];
            end else begin
                pend <= 1'b1;
                cnt  <= lat - 1;
                pa   <= mem_addr[3:0];
            end
        end
        if (mem_we)
            for (int i = 0; i < 4; i++)
                if (mem_be[i]) mem[mem_addr[3:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] op, input logic [31:0] b,
                         input logic [15:0] o, input logic [31:0] wd);
        req_valid = 1'b1; req_op = op; req_base = b; req_offset = o; req_wdata = wd;
    endtask

    function automatic logic [31:0] ref_load(input logic [5:0] op,
                                             input logic [31:0] w, input int ln);
        logic [31:0] s;
        s = w >> (8 * ln);
        case (op)
            6'h03: return {24'h0, s[7:0]};
            6'h04: return {{24{s[7]}}, s[7:0]};
            6'h05: return {16'h0, s[15:0]};
            6'h06: return {{16{s[15]}}, s[15:0]};
            default: return w;
        endcase
    endfunction

    task automatic do_load(input string req, input logic [5:0] op, input logic [31:0] b,
                           input logic [15:0] o, input logic [31:0] exp);
        @(negedge clk); drive(op, b, o, '0);
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        chk(req, "ld_valid", {31'h0, ld_valid}, 32'h1);
        chk(req, "ld_data", ld_data, exp);
    endtask

    task automatic t_reset;
        chk("R10", "ready after reset", {31'h0, req_ready}, 32'h1);
        chk("R9", "ld_valid after reset", {31'h0, ld_valid}, 32'h0);
        chk("R8", "misalign after reset", {31'h0, misalign}, 32'h0);
    endtask

    task automatic t_store_lanes;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            drive(6'h08, 32'h10, 16'(k), 32'hABCDEF00 | 32'(8'h11 * (k + 1)));
            #1;
            chk("R3", "byte be", {28'h0, mem_be}, 32'(4'b0001 << k));
            chk("R4", "byte we", {31'h0, mem_we}, 32'h1);
            chk("R4", "byte lane", {24'h0, mem_wdata[8*k +: 8]}, 32'(8'h11 * (k + 1)));
            chk("R1", "byte addr", {2'b0, mem_addr}, 32'h4);
        end
        @(negedge clk); req_valid = 1'b0;
        do_load("R7", 6'h07, 32'h10, 16'h0, 32'h44332211);
        @(negedge clk); drive(6'h09, 32'h14, 16'h2, 32'hDEADBEEF); #1;
        chk("R3", "half be", {28'h0, mem_be}, 32'hC);
        chk("R4", "half lanes", {16'h0, mem_wdata[31:16]}, 32'hBEEF);
        @(negedge clk); req_valid = 1'b0;
        do_load("R4", 6'h07, 32'h14, 16'h0, 32'hBEEF5678);
        @(negedge clk); drive(6'h0A, 32'h18, 16'h0, 32'hCAFEF00D); #1;
        chk("R3", "word be", {28'h0, mem_be}, 32'hF);
        @(negedge clk); req_valid = 1'b0;
        do_load("R7", 6'h07, 32'h18, 16'h0, 32'hCAFEF00D);
    endtask

    task automatic t_extend;
        for (int k = 0; k < 4; k++) begin
            do_load("R5", 6'h03, 32'h1C, 16'(k), ref_load(6'h03, mem[7], k));
            do_load("R6", 6'h04, 32'h1C, 16'(k), ref_load(6'h04, mem[7], k));
        end
        for (int k = 0; k < 4; k += 2) begin
            do_load("R5", 6'h05, 32'h1C, 16'(k), ref_load(6'h05, mem[7], k));
            do_load("R6", 6'h06, 32'h1C, 16'(k), ref_load(6'h06, mem[7], k));
        end
    endtask

    task automatic t_neg_offset;
        @(negedge clk); drive(6'h07, 32'h24, 16'hFFF8, '0); #1;
        chk("R1", "negative offset addr", {2'b0, mem_addr}, 32'h7);
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        chk("R1", "negative offset data", ld_data, 32'h8F7EA5C3);
    endtask

    task automatic t_misalign;
        @(negedge clk); drive(6'h05, 32'h1C, 16'h1, '0); #1;
        chk("R8", "odd half be", {28'h0, mem_be}, 32'h0);
        chk("R8", "odd half re", {31'h0, mem_re}, 32'h0);
        @(negedge clk); req_valid = 1'b0;
        chk("R8", "odd half flag", {31'h0, misalign}, 32'h1);
        @(negedge clk);
        chk("R8", "flag one cycle", {31'h0, misalign}, 32'h0);
        chk("R8", "no result", {31'h0, ld_valid}, 32'h0);
        @(negedge clk); drive(6'h0A, 32'h18, 16'h2, 32'hFFFFFFFF); #1;
        chk("R8", "unaligned word we", {31'h0, mem_we}, 32'h0);
        chk("R8", "unaligned word be", {28'h0, mem_be}, 32'h0);
        @(negedge clk); req_valid = 1'b0;
        chk("R8", "word flag", {31'h0, misalign}, 32'h1);
        do_load("R8", 6'h07, 32'h18, 16'h0, 32'hCAFEF00D);
        chk("R8", "aligned load no flag", {31'h0, misalign}, 32'h0);
        do_load("R8", 6'h03, 32'h1C, 16'h3, 32'h0000008F);
    endtask

    task automatic t_ignored;
        logic [5:0] ops [3] = '{6'h00, 6'h0B, 6'h3F};
        foreach (ops[n]) begin
            @(negedge clk); drive(ops[n], 32'h1D, 16'h0, 32'h12345678); #1;
            chk("R2", "no strobes", {30'h0, mem_re, mem_we}, 32'h0);
            chk("R2", "no be", {28'h0, mem_be}, 32'h0);
            @(negedge clk); req_valid = 1'b0;
            chk("R2", "no error", {31'h0, misalign}, 32'h0);
            @(negedge clk);
            chk("R2", "no result", {31'h0, ld_valid}, 32'h0);
        end
    endtask

    task automatic t_overlap;
        @(negedge clk); drive(6'h06, 32'h1C, 16'h2, '0);
        @(negedge clk);
        chk("R10", "ready on return", {31'h0, req_ready}, 32'h1);
        drive(6'h08, 32'h20, 16'h1, 32'h0000005A); #1;
        chk("R10", "store in return cycle", {31'h0, mem_we}, 32'h1);
        @(negedge clk); req_valid = 1'b0;
        chk("R9", "overlap valid", {31'h0, ld_valid}, 32'h1);
        chk("R6", "overlap data", ld_data, 32'hFFFF8F7E);
        @(negedge clk);
        chk("R9", "single pulse", {31'h0, ld_valid}, 32'h0);
        do_load("R4", 6'h03, 32'h20, 16'h1, 32'h0000005A);
        @(negedge clk); drive(6'h03, 32'h1C, 16'h0, '0);
        @(negedge clk); drive(6'h04, 32'h1C, 16'h1, '0);
        @(negedge clk); req_valid = 1'b0;
        chk("R5", "chained first", ld_data, 32'h000000C3);
        @(negedge clk);
        chk("R9", "chained second valid", {31'h0, ld_valid}, 32'h1);
        chk("R6", "chained second", ld_data, 32'hFFFFFFA5);
    endtask

    task automatic t_stall;
        lat = 2;
        @(negedge clk); drive(6'h07, 32'h1C, 16'h0, '0);
        @(negedge clk); drive(6'h08, 32'h20, 16'h2, 32'h00000077); #1;
        chk("R10", "refuse while waiting", {31'h0, req_ready}, 32'h0);
        chk("R10", "no write while waiting", {31'h0, mem_we}, 32'h0);
        @(negedge clk);
        chk("R10", "still refused", {30'h0, req_ready, mem_we}, 32'h0);
        @(negedge clk);
        chk("R10", "accept on return", {30'h0, req_ready, mem_we}, 32'h3);
        @(negedge clk); req_valid = 1'b0;
        chk("R9", "late data", ld_data, 32'h8F7EA5C3);
        lat = 0;
        do_load("R10", 6'h03, 32'h20, 16'h2, 32'h00000077);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        mem[5] = 32'h12345678;
        mem[7] = 32'h8F7EA5C3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store_lanes();
        t_extend();
        t_neg_offset();
        t_misalign();
        t_ignored();
        t_overlap();
        t_stall();
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule